// File: doc/BRIEF.md
# Decrementer Timer with Interrupt Request

This block is a software-loaded down-counter that produces an interrupt request when the count runs out. A register write loads a new count. The count then drops by one on each cycle where the block's own tick enable is high. That enable is separate from any time-base tick, so the decrementer can run at its own rate. A read strobe captures the live count into a read-data register.

When the count steps from zero to all ones, the block raises a level interrupt request. The sign bit goes from 0 to 1 at that step. The count does not stop there: it keeps counting down, so later reads return two's-complement negative values. Software may also load a count whose sign bit is already set. Such a count has already expired, and it still produces a request on the next tick instead of being lost. The request stays high until the acknowledge input clears it.

The request logic is a three-state machine (type `dect_state_e`):

- `ST_QUIET`: no request and nothing armed.
- `ST_ARMED`: a count with its sign bit set was loaded while no request was pending, and the request waits for the next tick.
- `ST_RAISED`: the request is high.

The transitions are named as follows:

- `EXPIRE`: a tick with no write, while the count is zero or the state is `ST_ARMED`. It goes to `ST_RAISED` from any state.
- `ARM`: a write whose bit 31 is 1. It goes from `ST_QUIET` to `ST_ARMED`, or from `ST_RAISED` to `ST_ARMED` together with an acknowledge.
- `DISARM`: a write whose bit 31 is 0. It goes from `ST_ARMED` to `ST_QUIET`.
- `CLEAR`: an acknowledge with no `EXPIRE`. It goes from `ST_RAISED` to `ST_QUIET`.

Top module: `decrementer_timer`

## Requirements
- R1: After reset, `count` is 0xFFFFFFFF, `irq_req` is 0 and `rd_data` is 0.
- R2: On a cycle with `tick_en` high and `wr_en` low, `count` decreases by one on the next edge. It wraps from 0 to 0xFFFFFFFF and keeps decreasing through negative values.
- R3: When `wr_en` is high, `count` takes `wr_data` on the next edge, and any `tick_en` in the same cycle has no effect on the count.
- R4: With `tick_en` and `wr_en` both low, `count` holds its value.
- R5: A cycle with `tick_en` high, `wr_en` low and `count` equal to 0 sets `irq_req` on the next edge.
- R6: This requirement covers a write with `wr_data` bit 31 equal to 1, made while no request is pending. The next tick without a write sets `irq_req`. A later write with bit 31 equal to 0, made before that tick, cancels it.
- R7: `irq_req` stays high until `ack` is high. Then it is low after the next edge, unless an `EXPIRE` happens in the same cycle, in which case the `EXPIRE` wins and `irq_req` stays high.
- R8: When `rd_en` is high, `rd_data` takes the current `count` on the next edge. Otherwise `rd_data` holds.
- R9: Counting down from the reset value does not raise `irq_req` until the count itself passes through zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Decrement enable, one count per high cycle |
| wr_en | input | 1 | Load strobe |
| wr_data | input | 32 | Value to load |
| rd_en | input | 1 | Read strobe |
| ack | input | 1 | Clears the interrupt request |
| count | output | 32 | Live count, two's complement |
| rd_data | output | 32 | Count captured by the last read strobe |
| irq_req | output | 1 | Level interrupt request |

## Verification
Several rules are checked on every cycle by the assertions:

- the single-step decrement, including the wrap to all ones;
- write priority over a tick, and holding when idle;
- setting the request on a zero-crossing or on an armed tick;
- keeping the request until an acknowledge, and clearing it after one;
- read capture.

Two behaviours appear only in the bench's scenarios. One is that an armed state is cancelled by a later non-negative write. The other is that the all-ones reset value ticks down without raising a request.

// File: rtl/dect_pkg.sv
package dect_pkg;
    typedef enum logic [1:0] {
        ST_QUIET  = 2'd0,
        ST_ARMED  = 2'd1,
        ST_RAISED = 2'd2
    } dect_state_e;
endpackage

// File: rtl/dect_count_reg.sv
module dect_count_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] count,
    output logic         at_zero
);
    localparam logic [W-1:0] ALL_ONES = '1;
    localparam logic [W-1:0] ONE      = W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= ALL_ONES;
        end else if (wr_en) begin
            count <= wr_data;
        end else if (tick_en) begin
            count <= count - ONE;
        end
    end

    assign at_zero = (count == '0);

    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !wr_en && count == '0) |=> (count == ALL_ONES));

    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !wr_en) |=> (count == $past(count) - ONE));

    a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (count == $past(wr_data)));

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !wr_en) |=> $stable(count));
endmodule

// File: rtl/dect_irq_fsm.sv
module dect_irq_fsm
    import dect_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic wr_en,
    input  logic wr_sign,
    input  logic at_zero,
    input  logic ack,
    output logic irq_req
);
    dect_state_e state, state_nx;
    logic        expire;

    // EXPIRE: a tick that is not overridden by a write
    assign expire = tick_en && !wr_en && (at_zero || state == ST_ARMED);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_QUIET: begin
                if (expire)                 state_nx = ST_RAISED;
                else if (wr_en && wr_sign)  state_nx = ST_ARMED;
            end
            ST_ARMED: begin
                if (expire)                 state_nx = ST_RAISED;
                else if (wr_en)             state_nx = wr_sign ? ST_ARMED : ST_QUIET;
            end
            ST_RAISED: begin
                if (expire)                 state_nx = ST_RAISED;
                else if (ack)               state_nx = (wr_en && wr_sign) ? ST_ARMED : ST_QUIET;
            end
            default:                        state_nx = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_QUIET;
        else        state <= state_nx;
    end

    always_comb begin
        irq_req = (state == ST_RAISED);
    end

    a_r5_zero_cross: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !wr_en && at_zero) |=> irq_req);

    a_r6_armed_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && tick_en && !wr_en) |=> irq_req);

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !ack) |=> irq_req);

    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && ack && !tick_en) |=> !irq_req);
endmodule

// File: rtl/dect_read_latch.sv
module dect_read_latch #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_en,
    input  logic [W-1:0] count,
    output logic [W-1:0] rd_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= count;
    end

    a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (rd_data == $past(count)));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/decrementer_timer.sv
module decrementer_timer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         wr_en,
    input  logic [31:0]  wr_data,
    input  logic         rd_en,
    input  logic         ack,
    output logic [31:0]  count,
    output logic [31:0]  rd_data,
    output logic         irq_req
);
    localparam int MSB = W - 1;

    logic at_zero;

    dect_count_reg #(.W(W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .count   (count),
        .at_zero (at_zero)
    );

    dect_irq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .wr_en   (wr_en),
        .wr_sign (wr_data[MSB]),
        .at_zero (at_zero),
        .ack     (ack),
        .irq_req (irq_req)
    );

    dect_read_latch #(.W(W)) u_read (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .count   (count),
        .rd_data (rd_data)
    );
endmodule

// File: tb/decrementer_timer_tb.sv
module decrementer_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0, ack = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] count, rd_data;
    logic        irq_req;

    int n_checks = 0;
    int n_fail = 0;
    string req_tag = "R1";

    // bench reference state: 0 quiet, 1 armed, 2 raised
    logic [31:0] m_count = 32'hFFFF_FFFF;
    logic [31:0] m_rd = '0;
    int          m_st = 0;

    always #2 clk = ~clk;

    decrementer_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .ack(ack),
        .count(count), .rd_data(rd_data), .irq_req(irq_req)
    );

    function automatic int next_state(int st, logic t, logic w, logic [31:0] d,
                                      logic a, logic [31:0] c);
        logic exp_ev = t && !w && (c == 32'd0 || st == 1);
        if (exp_ev) return 2;
        if (st == 0) return (w && d[31]) ? 1 : 0;
        if (st == 1) return w ? (d[31] ? 1 : 0) : 1;
        if (a) return (w && d[31]) ? 1 : 0;
        return 2;
    endfunction

    task automatic check32(string what, logic [31:0] act, logic [31:0] exp_v);
        n_checks++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req_tag, what, act, exp_v);
        end
    endtask

    task automatic compare_all();
        check32("count", count, m_count);
        check32("rd_data", rd_data, m_rd);
        check32("irq_req", {31'd0, irq_req}, {31'd0, m_st == 2});
    endtask

    task automatic apply(logic t, logic w, logic [31:0] d, logic r, logic a);
        tick_en = t; wr_en = w; wr_data = d; rd_en = r; ack = a;
        m_st = next_state(m_st, t, w, d, a, m_count);
        if (r) m_rd = m_count;
        if (w) m_count = d;
        else if (t) m_count = m_count - 32'd1;
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        req_tag = "R1";
        compare_all();

        // R9: ticking from reset value raises nothing
        req_tag = "R9";
        for (int i = 0; i < 5; i++) apply(1, 0, 0, 0, 0);

        // R3: write beats a simultaneous tick
        req_tag = "R3";
        apply(1, 1, 32'd3, 0, 0);
        apply(0, 0, 0, 0, 0);

        // R2 and R5: count down to zero and past it
        req_tag = "R5";
        for (int i = 0; i < 5; i++) apply(1, 0, 0, 1, 0);
        req_tag = "R2";
        apply(1, 0, 0, 1, 0);

        // R7: held without ack, cleared by ack
        req_tag = "R7";
        apply(0, 0, 0, 0, 0);
        apply(0, 0, 0, 0, 1);
        apply(0, 0, 0, 0, 0);

        // R6: negative load fires on next tick
        req_tag = "R6";
        apply(0, 1, 32'h8000_0010, 0, 0);
        apply(0, 0, 0, 0, 0);
        apply(1, 0, 0, 1, 0);
        apply(0, 0, 0, 0, 1);
        // R6: non-negative write cancels arming
        apply(0, 1, 32'hFFFF_FFF0, 0, 0);
        apply(0, 1, 32'd100, 0, 0);
        apply(1, 0, 0, 0, 0);
        apply(1, 0, 0, 0, 0);

        // R7: ack coinciding with expiry keeps the request
        req_tag = "R7";
        apply(0, 1, 32'd0, 0, 0);
        apply(1, 0, 0, 0, 0);
        apply(0, 1, 32'd0, 0, 1);
        apply(1, 0, 0, 0, 1);
        apply(0, 0, 0, 0, 1);

        // R4: hold
        req_tag = "R4";
        apply(0, 0, 0, 1, 0);
        apply(0, 0, 0, 0, 0);

        // R8 and mixed: constrained random
        req_tag = "R8 random";
        for (int i = 0; i < 4000; i++) begin
            logic t = ($urandom % 3) != 0;
            logic w = ($urandom % 10) == 0;
            int   sel = $urandom % 4;
            logic [31:0] d = (sel == 0) ? ($urandom % 4) :
                             (sel == 1) ? (32'hFFFF_FFF0 | ($urandom % 16)) :
                             (sel == 2) ? ($urandom % 16) : $urandom;
            apply(t, w, d, ($urandom % 4) == 0, ($urandom % 5) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule